// File: doc/BRIEF.md
# Execution Unit Reservation and Issue Scheduler

This block sits between instruction decode and the execution units of a core that has five execution resources: two integer ALUs, one memory pipe and two floating-point ALUs. Each cycle it may receive one operation, tagged with its operation class. Every class has its own set of permitted units, its own preference order when more than one unit fits, a result latency, and the number of cycles it holds its unit. From these the block decides whether the operation can issue in the same cycle.

Each unit has a down-counter that holds the number of cycles it remains occupied after the current one. An operation issues only when a permitted unit's counter is zero. On issue, the chosen unit's counter is loaded from the class occupancy. The outputs are a grant, the code of the unit that was chosen, and the result latency. A downstream scoreboard uses the latency to release the destination register. A stall is raised when a request cannot be placed. Divides and non-pipelined multiplies block their unit for many cycles. A serialising class needs every unit idle and takes all five for one cycle.

Top module: `fu_sched`

## Requirements
- R1: Unit codes are 0 integer ALU 1, 1 integer ALU 2, 2 memory, 3 FP ALU 1, 4 FP ALU 2, and 5 for all units together. Grant, unit and latency are combinational on the request in the same cycle. When there is no grant, the unit and latency outputs read 0.
- R2: Class 0 (simple integer) takes either integer ALU with latency 1. ALU 1 (code 0) is chosen whenever it is free.
- R3: Class 1 (branch, jump, call, conditional move, trap) issues only to unit 0. Class 2 (HI/LO moves) issues only to unit 1. Both have latency 1.
- R4: Class 3 (pipelined three-operand multiply) issues to unit 1 with latency 5 and holds it for one cycle, so back-to-back issues are all granted.
- R5: Class 4 (multiply, multiply-add) issues to unit 1 with latency 7 and holds it for 7 cycles.
- R6: Classes 5 and 6 (32-bit and 64-bit integer divide) hold unit 1 for 12 and 25 cycles. Their latency equals the hold time.
- R7: Classes 7, 8 and 9 (integer load; FP load or coprocessor move; store or prefetch) use unit 2, with latencies 3, 4 and 0.
- R8: Class 10 (FP add, multiply, multiply-add) tries unit 4 before unit 3, with latency 6.
- R9: Class 11 (FP abs, compare, move, negate) and class 12 (FP convert) use only unit 3, with latencies 2 and 4.
- R10: Classes 13 and 14 (single- and double-precision FP divide or square root, including reciprocal forms) hold unit 3 for 12 and 19 cycles. Their latency equals the hold time.
- R11: Class 15 (serialising) issues only when all five units are free. It reports unit code 5 with latency 1.
- R12: A valid request that is not granted raises stall and reserves nothing. With no valid request, neither grant nor stall is raised.
- R13: Synchronous active-high reset frees every unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An operation is offered this cycle |
| req_class | input | 4 | Operation class code |
| issue_grant | output | 1 | The operation issues this cycle |
| issue_stall | output | 1 | The operation is offered but cannot issue |
| issue_unit | output | 3 | Code of the chosen unit |
| issue_lat | output | 5 | Result latency of the issued operation |

## Verification
The assertions take for granted three things about the inputs. Reset is held at the start of time. `req_valid` and `req_class` are never unknown. Both are stable across the clock edge. All sixteen class codes are defined, so any 4-bit value is legal. The stimulus changes its inputs only on the falling edge, asserts reset before the first request, and never offers a request while reset is high.

// File: rtl/fu_sched_pkg.sv
package fu_sched_pkg;

    localparam int NUM_UNITS = 5;
    localparam int MAX_OCC   = 25;
    localparam int CNT_W     = $clog2(MAX_OCC + 1);
    localparam int LAT_W     = 5;
    localparam int CLS_W     = 4;
    localparam int UNIT_W    = 3;

    typedef enum logic [CLS_W-1:0] {
        C_INT_SIMPLE = 4'd0,
        C_INT_CTRL   = 4'd1,
        C_HILO       = 4'd2,
        C_MUL_PIPE   = 4'd3,
        C_MUL_BLOCK  = 4'd4,
        C_DIV_W      = 4'd5,
        C_DIV_D      = 4'd6,
        C_LD_INT     = 4'd7,
        C_LD_FP      = 4'd8,
        C_ST         = 4'd9,
        C_FP_ARITH   = 4'd10,
        C_FP_SIMPLE  = 4'd11,
        C_FP_CVT     = 4'd12,
        C_FDIV_S     = 4'd13,
        C_FDIV_D     = 4'd14,
        C_SERIAL     = 4'd15
    } op_class_e;

    typedef enum logic [UNIT_W-1:0] {
        U_ALU1  = 3'd0,
        U_ALU2  = 3'd1,
        U_MEM   = 3'd2,
        U_FALU1 = 3'd3,
        U_FALU2 = 3'd4,
        U_ALL   = 3'd5
    } unit_e;

    typedef struct packed {
        logic             need_all;
        logic             has_alt;
        unit_e            first;
        unit_e            alt;
        logic [LAT_W-1:0] lat;
        logic [CNT_W-1:0] occ;
    } class_info_t;

    function automatic class_info_t mk(logic all, logic alt_ok, unit_e f, unit_e a,
                                       int lat, int occ);
        class_info_t r;
        r.need_all = all;
        r.has_alt  = alt_ok;
        r.first    = f;
        r.alt      = a;
        r.lat      = LAT_W'(lat);
        r.occ      = CNT_W'(occ);
        return r;
    endfunction

    function automatic class_info_t class_info(op_class_e c);
        case (c)
            C_INT_SIMPLE: return mk(1'b0, 1'b1, U_ALU1,  U_ALU2,  1, 1);
            C_INT_CTRL:   return mk(1'b0, 1'b0, U_ALU1,  U_ALU1,  1, 1);
            C_HILO:       return mk(1'b0, 1'b0, U_ALU2,  U_ALU2,  1, 1);
            C_MUL_PIPE:   return mk(1'b0, 1'b0, U_ALU2,  U_ALU2,  5, 1);
            C_MUL_BLOCK:  return mk(1'b0, 1'b0, U_ALU2,  U_ALU2,  7, 7);
            C_DIV_W:      return mk(1'b0, 1'b0, U_ALU2,  U_ALU2, 12, 12);
            C_DIV_D:      return mk(1'b0, 1'b0, U_ALU2,  U_ALU2, 25, 25);
            C_LD_INT:     return mk(1'b0, 1'b0, U_MEM,   U_MEM,   3, 1);
            C_LD_FP:      return mk(1'b0, 1'b0, U_MEM,   U_MEM,   4, 1);
            C_ST:         return mk(1'b0, 1'b0, U_MEM,   U_MEM,   0, 1);
            C_FP_ARITH:   return mk(1'b0, 1'b1, U_FALU2, U_FALU1, 6, 1);
            C_FP_SIMPLE:  return mk(1'b0, 1'b0, U_FALU1, U_FALU1, 2, 1);
            C_FP_CVT:     return mk(1'b0, 1'b0, U_FALU1, U_FALU1, 4, 1);
            C_FDIV_S:     return mk(1'b0, 1'b0, U_FALU1, U_FALU1, 12, 12);
            C_FDIV_D:     return mk(1'b0, 1'b0, U_FALU1, U_FALU1, 19, 19);
            default:      return mk(1'b1, 1'b0, U_ALL,   U_ALL,   1, 1);
        endcase
    endfunction

endpackage

// File: rtl/fu_busy_ctr.sv
module fu_busy_ctr
    import fu_sched_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] occ,
    output logic             free
);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= occ - CNT_W'(1);
        end else if (remain != '0) begin
            remain <= remain - CNT_W'(1);
        end
    end

    assign free = (remain == '0);

    AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
        load |-> remain == '0);  // R12

    AST_COUNTS_DOWN: assert property (@(posedge clk) disable iff (rst)
        (!load && remain != '0) |=> remain == $past(remain) - CNT_W'(1));  // R6

    AST_RESET_FREES: assert property (@(posedge clk)
        rst |=> free);  // R13

endmodule

// File: rtl/fu_pick.sv
module fu_pick
    import fu_sched_pkg::*;
(
    input  logic                 req_valid,
    input  op_class_e            cls,
    input  logic [NUM_UNITS-1:0] free,
    output logic                 grant,
    output unit_e                unit,
    output logic [LAT_W-1:0]     lat,
    output logic [CNT_W-1:0]     occ,
    output logic [NUM_UNITS-1:0] claim
);

    class_info_t info;

    always_comb begin
        info  = class_info(cls);
        grant = 1'b0;
        unit  = U_ALU1;
        claim = '0;
        if (req_valid) begin
            if (info.need_all) begin
                if (&free) begin
                    grant = 1'b1;
                    unit  = U_ALL;
                    claim = '1;
                end
            end else if (free[info.first]) begin
                grant              = 1'b1;
                unit               = info.first;
                claim[info.first]  = 1'b1;
            end else if (info.has_alt && free[info.alt]) begin
                grant              = 1'b1;
                unit               = info.alt;
                claim[info.alt]    = 1'b1;
            end
        end
        lat = grant ? info.lat : '0;
        occ = info.occ;
    end

endmodule

// File: rtl/fu_sched.sv
module fu_sched
    import fu_sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [CLS_W-1:0]  req_class,
    output logic              issue_grant,
    output logic              issue_stall,
    output logic [UNIT_W-1:0] issue_unit,
    output logic [LAT_W-1:0]  issue_lat
);

    op_class_e            cls;
    logic [NUM_UNITS-1:0] free;
    logic [NUM_UNITS-1:0] claim;
    logic [CNT_W-1:0]     occ;
    unit_e                unit;

    assign cls = op_class_e'(req_class);

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        fu_busy_ctr u_ctr (
            .clk  (clk),
            .rst  (rst),
            .load (claim[u]),
            .occ  (occ),
            .free (free[u])
        );
    end

    fu_pick u_pick (
        .req_valid (req_valid),
        .cls       (cls),
        .free      (free),
        .grant     (issue_grant),
        .unit      (unit),
        .lat       (issue_lat),
        .occ       (occ),
        .claim     (claim)
    );

    assign issue_unit  = issue_grant ? unit : '0;
    assign issue_stall = req_valid & ~issue_grant;

    AST_STALL_EXCL: assert property (@(posedge clk) disable iff (rst)
        issue_stall |-> !issue_grant);  // R12

    AST_SERIAL_ALL_FREE: assert property (@(posedge clk) disable iff (rst)
        (issue_grant && cls == C_SERIAL) |-> (&free && issue_unit == U_ALL));  // R11

    AST_DIV_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (issue_grant && cls == C_DIV_D) |=> !free[U_ALU2]);  // R6

    AST_INT_PREF: assert property (@(posedge clk) disable iff (rst)
        (issue_grant && cls == C_INT_SIMPLE && free[U_ALU1]) |-> issue_unit == U_ALU1);  // R2

    AST_FP2_FIRST: assert property (@(posedge clk) disable iff (rst)
        (issue_grant && cls == C_FP_ARITH && free[U_FALU2]) |-> issue_unit == U_FALU2);  // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!issue_grant && !issue_stall));  // R12

endmodule

// File: tb/fu_sched_test.sv
module fu_sched_test;
    import fu_sched_pkg::*;

    localparam time PERIOD = 20ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [3:0] req_class = 4'd0;
    logic       issue_grant, issue_stall;
    logic [2:0] issue_unit;
    logic [4:0] issue_lat;

    int checks = 0;
    int failures = 0;

    always #(PERIOD / 2) clk = ~clk;

    fu_sched uut (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_class   (req_class),
        .issue_grant (issue_grant),
        .issue_stall (issue_stall),
        .issue_unit  (issue_unit),
        .issue_lat   (issue_lat)
    );

    // {class[3:0], unit[2:0], latency[4:0]} for each class issued from idle
    localparam logic [11:0] VEC [16] = '{
        {4'd0,  3'd0, 5'd1},  {4'd1,  3'd0, 5'd1},  {4'd2,  3'd1, 5'd1},
        {4'd3,  3'd1, 5'd5},  {4'd4,  3'd1, 5'd7},  {4'd5,  3'd1, 5'd12},
        {4'd6,  3'd1, 5'd25}, {4'd7,  3'd2, 5'd3},  {4'd8,  3'd2, 5'd4},
        {4'd9,  3'd2, 5'd0},  {4'd10, 3'd4, 5'd6},  {4'd11, 3'd3, 5'd2},
        {4'd12, 3'd3, 5'd4},  {4'd13, 3'd3, 5'd12}, {4'd14, 3'd3, 5'd19},
        {4'd15, 3'd5, 5'd1}
    };

    task automatic check(string req, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    task automatic apply(logic v, logic [3:0] c);
        @(negedge clk);
        req_valid = v;
        req_class = c;
        #2;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) apply(1'b0, 4'd0);
    endtask

    task automatic expect_issue(string req, logic [3:0] c, int unit, int lat);
        apply(1'b1, c);
        check(req, "grant", int'(issue_grant), 1);
        check(req, "stall", int'(issue_stall), 0);
        check(req, "unit", int'(issue_unit), unit);
        check(req, "latency", int'(issue_lat), lat);
    endtask

    task automatic expect_stall(string req, logic [3:0] c);
        apply(1'b1, c);
        check(req, "grant", int'(issue_grant), 0);
        check(req, "stall", int'(issue_stall), 1);
        check(req, "unit", int'(issue_unit), 0);
        check(req, "latency", int'(issue_lat), 0);
    endtask

    // issue a blocking class, then probe the unit every cycle until it frees
    task automatic hold_test(string req, logic [3:0] c, int unit, int occ,
                             logic [3:0] probe, int probe_lat);
        expect_issue(req, c, unit, occ);
        for (int k = 1; k < occ; k++) expect_stall(req, probe);
        expect_issue(req, probe, unit, probe_lat);
        idle(2);
    endtask

    initial begin
        #(PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12 R13: quiet outputs after reset with no request
        #2;
        check("R13", "grant", int'(issue_grant), 0);
        check("R12", "stall", int'(issue_stall), 0);

        // R1..R11: each class from an idle machine
        for (int i = 0; i < 16; i++) begin
            expect_issue("R1", VEC[i][11:8], int'(VEC[i][7:5]), int'(VEC[i][4:0]));
            idle(26);
        end

        // R4: pipelined multiply back to back
        expect_issue("R4", 4'd3, 1, 5);
        expect_issue("R4", 4'd3, 1, 5);
        expect_issue("R4", 4'd3, 1, 5);
        idle(2);

        // R5 R6 R10: hold times
        hold_test("R5",  4'd4,  1, 7,  4'd2,  1);
        hold_test("R6",  4'd5,  1, 12, 4'd2,  1);
        hold_test("R6",  4'd6,  1, 25, 4'd3,  5);
        hold_test("R10", 4'd13, 3, 12, 4'd11, 2);
        hold_test("R10", 4'd14, 3, 19, 4'd12, 4);

        // R2 R3: other ALU stays usable while ALU 2 divides
        expect_issue("R6", 4'd6, 1, 25);
        expect_issue("R2", 4'd0, 0, 1);
        expect_issue("R3", 4'd1, 0, 1);
        expect_stall("R3", 4'd2);
        // R7: memory pipe independent
        expect_issue("R7", 4'd9, 2, 0);
        // R11: serialising class blocked by busy unit
        expect_stall("R11", 4'd15);
        idle(25);
        expect_issue("R11", 4'd15, 5, 1);
        idle(2);

        // R8 R9: FP ALU 2 serves FP arith while FP ALU 1 divides
        expect_issue("R10", 4'd14, 3, 19);
        expect_issue("R8", 4'd10, 4, 6);
        expect_stall("R9", 4'd11);
        expect_stall("R9", 4'd12);
        idle(20);

        // R12: a stalled request reserves nothing
        expect_issue("R5", 4'd4, 1, 7);
        expect_stall("R12", 4'd4);
        idle(5);
        expect_issue("R12", 4'd4, 1, 7);
        idle(8);

        // R13: reset in the middle of a long divide frees the unit
        expect_issue("R13", 4'd6, 1, 25);
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #2;
        check("R13", "stall", int'(issue_stall), 0);
        expect_issue("R13", 4'd2, 1, 1);
        idle(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule